// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the 8-bit control word that a CPU writes to ask for a reduced-power state, and it contains the small sequencer that acts on that word. A write can send the core into sleep, stop or watch mode. A write can also fire a software reset pulse of fixed length. The block also keeps two settings: the halt-cycle count used in intermittent CPU operation, and the policy for the I/O pins while the clocks are stopped.

The block only produces control signals. Clock gating, oscillator control and the pad cells sit elsewhere and consume the mode code, the pin high-impedance request and the reset pulse.

Any interrupt returns the block to run mode. An external interrupt also clears the sleep and stop request bits. Reset is synchronous and active high.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the readback is 8'h18, the mode is run (2'b00), the halt selection is 2'b00, and both pins_hiz and sw_rst are low.
- R2: Readback layout: bit 0 is always 0, bits 4:3 always read 1, bits 2:1 are the halt field, bit 5 is the pin policy, bit 6 is the sleep request and bit 7 is the stop request.
- R3: An accepted write with bit 4 = 1 loads bits 2:1 into the halt selection output and bit 5 into the pin policy.
- R4: An accepted write with bit 4 = 1 sets the mode on the next clock edge. The mode becomes stop (2'b10) if bit 7 = 1. Otherwise it becomes sleep (2'b01) if bit 6 = 1. Otherwise it becomes watch (2'b11) if bit 3 = 0. Otherwise the mode is left unchanged.
- R5: When bit 7 and bit 6 are both written as 1 in one write, the mode becomes stop, never sleep.
- R6: A write sets the sleep and stop request bits when it writes them as 1. Writing 0 to them leaves them unchanged.
- R7: pins_hiz is high only while the mode is stop or watch and the pin policy bit is 1. It stays low in run and sleep.
- R8: An external interrupt returns the mode to run and clears the sleep and stop request bits. It wins over a write in the same cycle.
- R9: Any interrupt (any_irq) returns the mode to run and leaves the sleep and stop request bits unchanged.
- R10: An accepted write with bit 4 = 0 raises sw_rst from the next edge for exactly 3 cycles. All other fields of that write are ignored.
- R11: Writes are ignored while sw_rst is high. At the edge where sw_rst falls, the control word returns to 8'h18 and the mode returns to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data |
| ext_irq | input | 1 | External interrupt wake-up |
| any_irq | input | 1 | Any-interrupt wake-up |
| rd_data | output | 8 | Control word readback |
| mode | output | 2 | Current mode: 00 run, 01 sleep, 10 stop, 11 watch |
| halt_sel | output | 2 | Intermittent-operation halt-cycle selection |
| pins_hiz | output | 1 | Request to float the I/O pins |
| sw_rst | output | 1 | Internal software reset pulse |

## Verification
All 256 write values are applied from a freshly reset state. This separates the priority of stop over sleep over watch, the cases with no mode effect, and the pin-policy gating in each mode.

Every value with bit 4 clear also tests the reset pulse. During that pulse, a stop write and a second trigger write are issued, which tells a correctly ignored write apart from a re-armed or shortened pulse.

Directed sequences then cover the remaining behaviour. They check that the request bits stay set when written as 0, and they pulse each wake input separately. A write in the same cycle as an external interrupt shows which of the two takes priority.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int WORD_W = 8;
    localparam int HALT_W = 2;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_STOP  = 2'b10,
        MODE_WATCH = 2'b11
    } lpm_mode_e;

    // Control word, bit 7 first.
    typedef struct packed {
        logic              stop_req;
        logic              sleep_req;
        logic              pin_z;
        logic              srst_n;
        logic              watch_n;
        logic [HALT_W-1:0] halt;
        logic              rsvd;
    } lpm_word_s;

    localparam lpm_word_s RESET_WORD = '{
        stop_req: 1'b0, sleep_req: 1'b0, pin_z: 1'b0,
        srst_n: 1'b1, watch_n: 1'b1, halt: '0, rsvd: 1'b0
    };

    // Stop beats sleep, sleep beats watch; otherwise keep the current mode.
    function automatic lpm_mode_e pick_mode(
        input logic      stop_bit,
        input logic      sleep_bit,
        input logic      watch_n_bit,
        input lpm_mode_e cur
    );
        if (stop_bit)          return MODE_STOP;
        else if (sleep_bit)    return MODE_SLEEP;
        else if (!watch_n_bit) return MODE_WATCH;
        else                   return cur;
    endfunction

    function automatic logic clocks_stopped(input lpm_mode_e m);
        return (m == MODE_STOP) || (m == MODE_WATCH);
    endfunction

endpackage

// File: rtl/lpm_srst_gen.sv
module lpm_srst_gen #(
    parameter int PULSE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic pulse,
    output logic done
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (trigger) begin
            cnt_q <= CNT_W'(PULSE_CYCLES);
        end
    end

    assign pulse = (cnt_q != '0);
    assign done  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              cfg_wr,
    input  logic [HALT_W-1:0] wr_halt,
    input  logic              wr_pin_z,
    input  logic              wr_sleep,
    input  logic              wr_stop,
    input  logic              ext_irq,
    output logic [HALT_W-1:0] halt_q,
    output logic              pin_z_q,
    output logic              sleep_q,
    output logic              stop_q
);
    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            halt_q  <= RESET_WORD.halt;
            pin_z_q <= RESET_WORD.pin_z;
            sleep_q <= RESET_WORD.sleep_req;
            stop_q  <= RESET_WORD.stop_req;
        end else begin
            if (cfg_wr) begin
                halt_q  <= wr_halt;
                pin_z_q <= wr_pin_z;
            end
            if (ext_irq) begin
                sleep_q <= 1'b0;
                stop_q  <= 1'b0;
            end else if (cfg_wr) begin
                if (wr_sleep) sleep_q <= 1'b1;
                if (wr_stop)  stop_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_clr,
    input  logic      cfg_wr,
    input  logic      wr_stop,
    input  logic      wr_sleep,
    input  logic      wr_watch_n,
    input  logic      ext_irq,
    input  logic      any_irq,
    output lpm_mode_e mode_q
);
    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            mode_q <= MODE_RUN;
        end else if (ext_irq || any_irq) begin
            mode_q <= MODE_RUN;
        end else if (cfg_wr) begin
            mode_q <= pick_mode(wr_stop, wr_sleep, wr_watch_n, mode_q);
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int PULSE_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ext_irq,
    input  logic              any_irq,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        mode,
    output logic [HALT_W-1:0] halt_sel,
    output logic              pins_hiz,
    output logic              sw_rst
);
    lpm_word_s   wr_word;
    lpm_word_s   rd_word;
    lpm_mode_e   mode_q;
    logic        wr_fire;
    logic        srst_req;
    logic        cfg_wr;
    logic        soft_clr;
    logic        pin_z_q;
    logic        sleep_q;
    logic        stop_q;

    assign wr_word  = lpm_word_s'(wr_data);
    assign wr_fire  = wr_en && !sw_rst;
    assign srst_req = wr_fire && !wr_word.srst_n;
    assign cfg_wr   = wr_fire && wr_word.srst_n;

    lpm_srst_gen #(.PULSE_CYCLES(PULSE_CYCLES)) srst_i (
        .clk     (clk),
        .rst     (rst),
        .trigger (srst_req),
        .pulse   (sw_rst),
        .done    (soft_clr)
    );

    lpm_cfg_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .cfg_wr   (cfg_wr),
        .wr_halt  (wr_word.halt),
        .wr_pin_z (wr_word.pin_z),
        .wr_sleep (wr_word.sleep_req),
        .wr_stop  (wr_word.stop_req),
        .ext_irq  (ext_irq),
        .halt_q   (halt_sel),
        .pin_z_q  (pin_z_q),
        .sleep_q  (sleep_q),
        .stop_q   (stop_q)
    );

    lpm_mode_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .soft_clr   (soft_clr),
        .cfg_wr     (cfg_wr),
        .wr_stop    (wr_word.stop_req),
        .wr_sleep   (wr_word.sleep_req),
        .wr_watch_n (wr_word.watch_n),
        .ext_irq    (ext_irq),
        .any_irq    (any_irq),
        .mode_q     (mode_q)
    );

    always_comb begin
        rd_word           = RESET_WORD;
        rd_word.stop_req  = stop_q;
        rd_word.sleep_req = sleep_q;
        rd_word.pin_z     = pin_z_q;
        rd_word.halt      = halt_sel;
    end

    assign rd_data  = rd_word;
    assign mode     = mode_q;
    assign pins_hiz = pin_z_q && clocks_stopped(mode_q);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int PULSE_CYCLES = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ext_irq,
    input logic       any_irq,
    input logic [7:0] rd_data,
    input logic [1:0] mode,
    input logic       pins_hiz,
    input logic       sw_rst
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)         run_len <= '0;
        else if (sw_rst) run_len <= run_len + 16'd1;
        else             run_len <= '0;
    end

    a_r10_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_rst) |-> run_len == 16'(PULSE_CYCLES));

    a_r10_pulse_start: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sw_rst && !wr_data[4]) |=> sw_rst);

    a_r11_post_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_rst) |-> (rd_data == 8'h18 && mode == 2'b00));

    a_r7_hiz_gate: assert property (@(posedge clk) disable iff (rst)
        pins_hiz |-> mode[1]);

    a_r8_ext_wake: assert property (@(posedge clk) disable iff (rst)
        ext_irq |=> (mode == 2'b00 && rd_data[7:6] == 2'b00));

    a_r9_any_wake: assert property (@(posedge clk) disable iff (rst)
        any_irq |=> mode == 2'b00);

    a_r5_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sw_rst && wr_data[4] && wr_data[7] && !ext_irq && !any_irq)
        |=> mode == 2'b10);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ext_irq  (ext_irq),
    .any_irq  (any_irq),
    .rd_data  (rd_data),
    .mode     (mode),
    .pins_hiz (pins_hiz),
    .sw_rst   (sw_rst)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_irq = 1'b0;
    logic       any_irq = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] mode;
    logic [1:0] halt_sel;
    logic       pins_hiz;
    logic       sw_rst;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lpm_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ext_irq(ext_irq), .any_irq(any_irq), .rd_data(rd_data),
        .mode(mode), .halt_sel(halt_sel), .pins_hiz(pins_hiz), .sw_rst(sw_rst)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    // One clock edge with the given inputs; returns just after the next falling edge.
    task automatic cyc(input logic we, input logic [7:0] d, input logic e, input logic a);
        wr_en = we; wr_data = d; ext_irq = e; any_irq = a;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; ext_irq = 1'b0; any_irq = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [1:0] exp_mode(input logic [7:0] d);
        if (!d[4])     return 2'b00;
        else if (d[7]) return 2'b10;
        else if (d[6]) return 2'b01;
        else if (!d[3]) return 2'b11;
        else           return 2'b00;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 00 expected 01");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk_eq("R1 rd_data", rd_data, 8'h18);
        chk_eq("R1 mode", {6'd0, mode}, 8'h00);
        chk_eq("R1 halt_sel", {6'd0, halt_sel}, 8'h00);
        chk_eq("R1 pins_hiz", {7'd0, pins_hiz}, 8'h00);
        chk_eq("R1 sw_rst", {7'd0, sw_rst}, 8'h00);

        // Sweep every write value from a freshly reset state (R2 R3 R4 R5 R7 R10 R11)
        for (int v = 0; v < 256; v++) begin
            logic [7:0] d;
            logic [1:0] m;
            logic [7:0] rd_e;
            d = 8'(v);
            do_reset();
            cyc(1'b1, d, 1'b0, 1'b0);
            m = exp_mode(d);
            rd_e = d[4] ? {d[7], d[6], d[5], 2'b11, d[2:1], 1'b0} : 8'h18;
            chk_eq("R4 R5 mode after write", {6'd0, mode}, {6'd0, m});
            chk_eq("R2 R6 readback after write", rd_data, rd_e);
            chk_eq("R3 halt_sel", {6'd0, halt_sel}, {6'd0, (d[4] ? d[2:1] : 2'b00)});
            chk_eq("R7 pins_hiz", {7'd0, pins_hiz}, {7'd0, (d[4] && d[5] && m[1])});
            chk_eq("R10 sw_rst start", {7'd0, sw_rst}, {7'd0, !d[4]});
            if (!d[4]) begin
                cyc(1'b1, 8'h98, 1'b0, 1'b0);
                chk_eq("R10 sw_rst cycle 2", {7'd0, sw_rst}, 8'h01);
                chk_eq("R11 write ignored in pulse", {6'd0, mode}, 8'h00);
                cyc(1'b1, 8'h00, 1'b0, 1'b0);
                chk_eq("R10 sw_rst cycle 3", {7'd0, sw_rst}, 8'h01);
                cyc(1'b0, 8'h00, 1'b0, 1'b0);
                chk_eq("R10 sw_rst ends", {7'd0, sw_rst}, 8'h00);
                chk_eq("R11 word restored", rd_data, 8'h18);
                chk_eq("R11 mode restored", {6'd0, mode}, 8'h00);
                cyc(1'b0, 8'h00, 1'b0, 1'b0);
                chk_eq("R11 no retrigger", {7'd0, sw_rst}, 8'h00);
            end
        end

        // R6: request bits stay set when written as zero
        do_reset();
        cyc(1'b1, 8'h50, 1'b0, 1'b0);
        chk_eq("R4 sleep over watch", {6'd0, mode}, 8'h01);
        cyc(1'b1, 8'h18, 1'b0, 1'b0);
        chk_eq("R6 sleep kept", {6'd0, mode}, 8'h01);
        chk_eq("R6 sleep bit kept", rd_data, 8'h58);
        cyc(1'b1, 8'h98, 1'b0, 1'b0);
        chk_eq("R4 stop from sleep", {6'd0, mode}, 8'h02);
        chk_eq("R6 both bits", rd_data, 8'hD8);

        // R8: external interrupt clears bits and wakes
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk_eq("R8 ext wake mode", {6'd0, mode}, 8'h00);
        chk_eq("R8 ext clears bits", rd_data, 8'h18);
        cyc(1'b1, 8'hB8, 1'b1, 1'b0);
        chk_eq("R8 ext beats write mode", {6'd0, mode}, 8'h00);
        chk_eq("R8 ext beats write bits", rd_data, 8'h38);

        // R7 R9: watch with float policy, any interrupt wakes
        do_reset();
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        chk_eq("R4 watch", {6'd0, mode}, 8'h03);
        chk_eq("R7 hiz in watch", {7'd0, pins_hiz}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk_eq("R9 any wake mode", {6'd0, mode}, 8'h00);
        chk_eq("R7 hiz off in run", {7'd0, pins_hiz}, 8'h00);
        cyc(1'b1, 8'hF8, 1'b0, 1'b0);
        chk_eq("R7 hiz in stop", {7'd0, pins_hiz}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk_eq("R9 any wake from stop", {6'd0, mode}, 8'h00);
        chk_eq("R9 bits kept", rd_data, 8'hF8);
        cyc(1'b1, 8'h78, 1'b0, 1'b0);
        chk_eq("R7 no hiz in sleep", {7'd0, pins_hiz}, 8'h00);
        chk_eq("R4 sleep mode", {6'd0, mode}, 8'h01);

        finish_run();
    end
endmodule